// File: doc/BRIEF.md
# Framed CRC Insert and Check Unit

This block sits on a byte-wide character stream in which every byte carries a control flag, as found just ahead of an 8b/10b encoder. It has a transmit half and a receive half. The two halves share the delimiter configuration. Each half has its own enable.

On transmit, a start delimiter opens a CRC-32 region. The sender leaves four spare byte slots just before each end delimiter. The unit delays the stream through a fixed pipeline and overwrites those four slots with the inverted CRC remainder. A test input can corrupt the inserted value on purpose. The receiver then flags the frame, which is useful in a loopback test.

On receive, the stream passes through one register, with or without checking. While a frame is open, the unit runs the same CRC over the payload and the four received remainder bytes. It drives a frame-in-progress flag. When the end delimiter leaves the block, it pulses an error flag if the register does not hold the CRC-32 residue.

Top module: `framed_crc_unit`

## Requirements
- R1: With `tx_crc_en` high, every transmit character (flag and data) leaves the block exactly 6 clock cycles after it enters.
- R2: The remainder is CRC-32 with polynomial 0x04C11DB7. The register is preset to all ones and shifts data bits most significant bit first. It covers the data bytes after the start delimiter, up to but not including the four slots before the end delimiter. The result is inverted and written into those four slots most significant byte first, each with the control flag low. The payload "123456789" gives FC 89 19 18. An empty payload gives 00 00 00 00.
- R3: A start delimiter is a byte with the control flag at 1 and data equal to `sop_code`. An end delimiter is a byte with the control flag at 1 and data equal to `eop_code`. Both codes are inputs.
- R4: If `tx_force_err` is high in the same cycle that an end delimiter is presented on the transmit input, bit 0 of the last remainder byte of that frame is inverted.
- R5: With `tx_crc_en` low, the transmit outputs equal the transmit inputs in the same cycle.
- R6: The receive data and flag outputs equal the receive inputs one cycle earlier, whatever the state of `rx_crc_en`.
- R7: With `rx_crc_en` high, `rx_checking` is high on every output cycle from a start delimiter through the end delimiter that closes the frame. It is low elsewhere.
- R8: `rx_crc_err` is a one-cycle pulse, in the same cycle as the closing end delimiter on the receive output. It fires only when the CRC over the payload and remainder bytes differs from the residue 0xC704DD7B. A clean frame gives no pulse.
- R9: A start delimiter that arrives while a frame is open restarts the CRC on both sides. Only the bytes after the last start delimiter are covered.
- R10: An end delimiter with no open frame passes through unchanged. No bytes are substituted, `rx_checking` stays low and no error pulse is produced.
- R11: With `rx_crc_en` low, `rx_checking` and `rx_crc_err` stay low.
- R12: After reset, the delayed transmit outputs, the receive outputs and both receive flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sop_code | input | 8 | Data value of the start delimiter |
| eop_code | input | 8 | Data value of the end delimiter |
| tx_crc_en | input | 1 | Transmit CRC insertion enable |
| tx_force_err | input | 1 | Corrupt the remainder of the frame whose end delimiter is presented now |
| tx_k_in | input | 1 | Transmit input control flag |
| tx_data_in | input | 8 | Transmit input byte |
| tx_k_out | output | 1 | Transmit output control flag |
| tx_data_out | output | 8 | Transmit output byte |
| rx_crc_en | input | 1 | Receive CRC checking enable |
| rx_k_in | input | 1 | Receive input control flag |
| rx_data_in | input | 8 | Receive input byte |
| rx_k_out | output | 1 | Receive output control flag |
| rx_data_out | output | 8 | Receive output byte |
| rx_checking | output | 1 | Frame in progress on the receive output |
| rx_crc_err | output | 1 | CRC mismatch pulse, aligned with the end delimiter |

## Verification
The assertions check several receive rules on every cycle:
- the one-cycle pass-through of the receive data,
- that an error pulse only ever falls on an end delimiter inside a checked frame and never lasts two cycles,
- that a start delimiter always opens the checking window,
- that the flags stay quiet when checking is off.

The values of the inserted remainder bytes, the six-cycle transmit delay, the effect of the forced error, the restart on a repeated start delimiter and the handling of an orphan end delimiter are shown only by the bench. It runs loopback frames through the unit, some with a bit flipped on the line, and compares the results against a CRC model of its own.

// File: rtl/fcu_pkg.sv
`timescale 1ns/1ps
package fcu_pkg;

    localparam int SYM_W     = 8;
    localparam int CRC_W     = 32;
    localparam int CRC_BYTES = CRC_W / SYM_W;
    localparam int TX_LAT    = CRC_BYTES + 2;
    localparam int SLOT_W    = $clog2(CRC_BYTES);

    localparam logic [CRC_W-1:0] CRC_POLY    = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_PRESET  = '1;
    localparam logic [CRC_W-1:0] CRC_RESIDUE = 32'hC704DD7B;

    typedef struct packed {
        logic             k;
        logic [SYM_W-1:0] d;
    } sym_t;

    typedef enum logic {
        FRM_IDLE = 1'b0,
        FRM_OPEN = 1'b1
    } frm_e;

    function automatic logic is_ctl(sym_t s, logic [SYM_W-1:0] code);
        return s.k && (s.d == code);
    endfunction

    // one byte through the CRC register, MSB of the byte first
    function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c,
                                                  logic [SYM_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/fcu_tx_insert.sv
`timescale 1ns/1ps
module fcu_tx_insert
    import fcu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             force_err,
    input  logic [SYM_W-1:0] sop_code,
    input  logic [SYM_W-1:0] eop_code,
    input  sym_t             in_s,
    output sym_t             out_s
);
    localparam int UPD   = CRC_BYTES;
    localparam int DEPTH = TX_LAT;

    sym_t             pipe_q [DEPTH];
    logic [CRC_BYTES-1:0] frc_q;
    logic [CRC_W-1:0] crc_q;
    frm_e             frm_q;

    logic             slot_hit;
    logic [SLOT_W-1:0] slot;
    logic             slot_frc;
    logic             subst;
    logic [CRC_W-1:0] fin;
    logic [CRC_W-1:0] fin_sh;
    logic [SYM_W-1:0] rem_byte;
    sym_t             upd_s;

    assign upd_s = pipe_q[UPD];

    // the oldest end delimiter in the look-ahead window sets the slot index
    always_comb begin
        slot_hit = 1'b0;
        slot     = '0;
        slot_frc = 1'b0;
        for (int j = 0; j < CRC_BYTES; j++) begin
            if (is_ctl(pipe_q[j], eop_code)) begin
                slot_hit = 1'b1;
                slot     = SLOT_W'(j);
                slot_frc = frc_q[j] && (j == CRC_BYTES - 1);
            end
        end
    end

    assign subst  = (frm_q == FRM_OPEN) && slot_hit &&
                    !is_ctl(upd_s, sop_code) && !is_ctl(upd_s, eop_code);
    assign fin    = ~crc_q;
    assign fin_sh = fin >> (SYM_W * (CRC_BYTES - 1 - int'(slot)));

    always_comb begin
        rem_byte = fin_sh[SYM_W-1:0];
        if (slot_frc) rem_byte[0] = ~rem_byte[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
            frc_q <= '0;
            crc_q <= CRC_PRESET;
            frm_q <= FRM_IDLE;
        end else begin
            pipe_q[0] <= in_s;
            for (int i = 1; i <= UPD; i++) pipe_q[i] <= pipe_q[i-1];
            pipe_q[DEPTH-1] <= subst ? sym_t'{k: 1'b0, d: rem_byte} : upd_s;
            frc_q <= {frc_q[CRC_BYTES-2:0], force_err};
            if (!en) begin
                frm_q <= FRM_IDLE;
            end else if (is_ctl(upd_s, sop_code)) begin
                crc_q <= CRC_PRESET;
                frm_q <= FRM_OPEN;
            end else if (is_ctl(upd_s, eop_code)) begin
                frm_q <= FRM_IDLE;
            end else if (frm_q == FRM_OPEN && !slot_hit) begin
                crc_q <= crc_step(crc_q, upd_s.d);
            end
        end
    end

    assign out_s = en ? pipe_q[DEPTH-1] : in_s;

endmodule

// File: rtl/fcu_rx_check.sv
`timescale 1ns/1ps
module fcu_rx_check
    import fcu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SYM_W-1:0] sop_code,
    input  logic [SYM_W-1:0] eop_code,
    input  sym_t             in_s,
    output sym_t             out_s,
    output logic             checking,
    output logic             crc_err
);
    logic [CRC_W-1:0] crc_q;
    frm_e             frm_q;
    sym_t             out_q;
    logic             chk_q;
    logic             err_q;
    logic             is_sop;
    logic             is_eop;

    assign is_sop = is_ctl(in_s, sop_code);
    assign is_eop = is_ctl(in_s, eop_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            chk_q <= 1'b0;
            err_q <= 1'b0;
            crc_q <= CRC_PRESET;
            frm_q <= FRM_IDLE;
        end else begin
            out_q <= in_s;
            chk_q <= en && (is_sop || frm_q == FRM_OPEN);
            err_q <= en && (frm_q == FRM_OPEN) && is_eop && !is_sop &&
                     (crc_q != CRC_RESIDUE);
            if (!en) begin
                frm_q <= FRM_IDLE;
            end else if (is_sop) begin
                crc_q <= CRC_PRESET;
                frm_q <= FRM_OPEN;
            end else if (is_eop) begin
                frm_q <= FRM_IDLE;
            end else if (frm_q == FRM_OPEN) begin
                crc_q <= crc_step(crc_q, in_s.d);
            end
        end
    end

    assign out_s    = out_q;
    assign checking = chk_q;
    assign crc_err  = err_q;

endmodule

// File: rtl/framed_crc_unit.sv
`timescale 1ns/1ps
module framed_crc_unit
    import fcu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SYM_W-1:0] sop_code,
    input  logic [SYM_W-1:0] eop_code,
    input  logic             tx_crc_en,
    input  logic             tx_force_err,
    input  logic             tx_k_in,
    input  logic [SYM_W-1:0] tx_data_in,
    output logic             tx_k_out,
    output logic [SYM_W-1:0] tx_data_out,
    input  logic             rx_crc_en,
    input  logic             rx_k_in,
    input  logic [SYM_W-1:0] rx_data_in,
    output logic             rx_k_out,
    output logic [SYM_W-1:0] rx_data_out,
    output logic             rx_checking,
    output logic             rx_crc_err
);
    sym_t tx_in_s, tx_out_s, rx_in_s, rx_out_s;

    assign tx_in_s = sym_t'{k: tx_k_in, d: tx_data_in};
    assign rx_in_s = sym_t'{k: rx_k_in, d: rx_data_in};

    fcu_tx_insert tx_i (
        .clk       (clk),
        .rst       (rst),
        .en        (tx_crc_en),
        .force_err (tx_force_err),
        .sop_code  (sop_code),
        .eop_code  (eop_code),
        .in_s      (tx_in_s),
        .out_s     (tx_out_s)
    );

    fcu_rx_check rx_i (
        .clk      (clk),
        .rst      (rst),
        .en       (rx_crc_en),
        .sop_code (sop_code),
        .eop_code (eop_code),
        .in_s     (rx_in_s),
        .out_s    (rx_out_s),
        .checking (rx_checking),
        .crc_err  (rx_crc_err)
    );

    assign tx_k_out    = tx_out_s.k;
    assign tx_data_out = tx_out_s.d;
    assign rx_k_out    = rx_out_s.k;
    assign rx_data_out = rx_out_s.d;

endmodule

// File: rtl/fcu_checker.sv
`timescale 1ns/1ps
module fcu_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] sop_code,
    input logic [7:0] eop_code,
    input logic       rx_crc_en,
    input logic       rx_k_in,
    input logic [7:0] rx_data_in,
    input logic       rx_k_out,
    input logic [7:0] rx_data_out,
    input logic       rx_checking,
    input logic       rx_crc_err
);
    logic armed_q;

    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    AST_RX_PASS_DELAY: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> ({rx_k_out, rx_data_out} == $past({rx_k_in, rx_data_in}))); // R6

    AST_ERR_ON_EOP: assert property (@(posedge clk) disable iff (rst)
        rx_crc_err |-> (rx_k_out && rx_data_out == eop_code)); // R8

    AST_ERR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        rx_crc_err |-> rx_checking); // R8

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_crc_err |=> !rx_crc_err); // R8

    AST_SOP_OPENS: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(rx_crc_en && rx_k_in && rx_data_in == sop_code))
        |-> rx_checking); // R7

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !$past(rx_crc_en)) |-> (!rx_checking && !rx_crc_err)); // R11

endmodule

bind framed_crc_unit fcu_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .sop_code    (sop_code),
    .eop_code    (eop_code),
    .rx_crc_en   (rx_crc_en),
    .rx_k_in     (rx_k_in),
    .rx_data_in  (rx_data_in),
    .rx_k_out    (rx_k_out),
    .rx_data_out (rx_data_out),
    .rx_checking (rx_checking),
    .rx_crc_err  (rx_crc_err)
);

// File: tb/framed_crc_unit_tb_top.sv
`timescale 1ns/1ps
module framed_crc_unit_tb_top;

    localparam int LAT  = 6;
    localparam int MAXS = 64;
    localparam int MAXL = 96;
    localparam logic [7:0] IDLE_D = 8'hBC;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] sop_code, eop_code;
    logic       tx_crc_en, tx_force_err, tx_k_in;
    logic [7:0] tx_data_in;
    logic       tx_k_out;
    logic [7:0] tx_data_out;
    logic       rx_crc_en;
    logic       rx_k_in;
    logic [7:0] rx_data_in;
    logic       rx_k_out;
    logic [7:0] rx_data_out;
    logic       rx_checking, rx_crc_err;
    logic [7:0] flip_mask;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    // loopback with an optional line corruption
    assign rx_k_in    = tx_k_out;
    assign rx_data_in = tx_data_out ^ flip_mask;

    framed_crc_unit dut_i (
        .clk(clk), .rst(rst), .sop_code(sop_code), .eop_code(eop_code),
        .tx_crc_en(tx_crc_en), .tx_force_err(tx_force_err),
        .tx_k_in(tx_k_in), .tx_data_in(tx_data_in),
        .tx_k_out(tx_k_out), .tx_data_out(tx_data_out),
        .rx_crc_en(rx_crc_en), .rx_k_in(rx_k_in), .rx_data_in(rx_data_in),
        .rx_k_out(rx_k_out), .rx_data_out(rx_data_out),
        .rx_checking(rx_checking), .rx_crc_err(rx_crc_err)
    );

    logic [7:0] pl [16];
    int         pl_n;
    logic       st_k [MAXS];
    logic [7:0] st_d [MAXS];
    int         slen, sop_first, eop_at, nlog;
    logic       lg_tk [MAXL];
    logic [7:0] lg_td [MAXL];
    logic       lg_rki [MAXL];
    logic [7:0] lg_rdi [MAXL];
    logic       lg_rk [MAXL];
    logic [7:0] lg_rd [MAXL];
    logic       lg_chk [MAXL];
    logic       lg_err [MAXL];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc();
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < pl_n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[31] ^ pl[i][b];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C11DB7;
            end
        end
        return ~c;
    endfunction

    task automatic add_sym(input logic k, input logic [7:0] d);
        st_k[slen] = k;
        st_d[slen] = d;
        slen++;
    endtask

    task automatic build_frame(input bit restart);
        slen = 0;
        add_sym(1'b1, IDLE_D);
        add_sym(1'b1, IDLE_D);
        sop_first = slen;
        if (restart) begin
            add_sym(1'b1, sop_code);
            add_sym(1'b0, 8'h11);
            add_sym(1'b0, 8'h22);
            add_sym(1'b0, 8'h33);
        end
        add_sym(1'b1, sop_code);
        for (int i = 0; i < pl_n; i++) add_sym(1'b0, pl[i]);
        for (int i = 0; i < 4; i++) add_sym(1'b0, 8'h00);
        eop_at = slen;
        add_sym(1'b1, eop_code);
        for (int i = 0; i < 8; i++) add_sym(1'b1, IDLE_D);
    endtask

    task automatic run(input bit txe, input bit rxe, input bit frc,
                       input int flip_at, input logic [7:0] mask);
        nlog = slen + 10;
        for (int t = 0; t < nlog; t++) begin
            @(negedge clk);
            tx_crc_en    = txe;
            rx_crc_en    = rxe;
            tx_k_in      = (t < slen) ? st_k[t] : 1'b1;
            tx_data_in   = (t < slen) ? st_d[t] : IDLE_D;
            tx_force_err = frc && (t == eop_at);
            flip_mask    = (t == flip_at) ? mask : 8'h00;
            #1;
            lg_tk[t]  = tx_k_out;   lg_td[t]  = tx_data_out;
            lg_rki[t] = rx_k_in;    lg_rdi[t] = rx_data_in;
            lg_rk[t]  = rx_k_out;   lg_rd[t]  = rx_data_out;
            lg_chk[t] = rx_checking; lg_err[t] = rx_crc_err;
        end
        flip_mask = 8'h00;
    endtask

    task automatic check_tx(input bit txe, input bit subst, input bit frc,
                            input string req);
        logic [31:0] fin = ref_crc();
        int lat = txe ? LAT : 0;
        int nbad = 0;
        logic [8:0] a0 = '0, e0 = '0;
        for (int t = 0; t < slen; t++) begin
            logic       ek = st_k[t];
            logic [7:0] ed = st_d[t];
            if (subst && t >= eop_at - 4 && t < eop_at) begin
                ek = 1'b0;
                ed = fin[8*(3-(t-(eop_at-4))) +: 8];
                if (frc && t == eop_at - 1) ed[0] = ~ed[0];
            end
            if ({lg_tk[t+lat], lg_td[t+lat]} != {ek, ed}) begin
                if (nbad == 0) begin
                    a0 = {lg_tk[t+lat], lg_td[t+lat]};
                    e0 = {ek, ed};
                end
                nbad++;
            end
        end
        check(nbad == 0, req, "tx stream", 32'(a0), 32'(e0));
    endtask

    task automatic check_rx(input bit rxe, input bit exp_err, input int lat,
                            input bit framed, input string req_pass,
                            input string req_flag);
        int npass = 0, nchk = 0, nerr = 0;
        logic [31:0] ca = 0, ce = 0;
        for (int t = 0; t + 1 < nlog; t++) begin
            bit ec, ee;
            if ({lg_rk[t+1], lg_rd[t+1]} != {lg_rki[t], lg_rdi[t]}) npass++;
            ec = rxe && framed && t >= sop_first + lat && t <= eop_at + lat;
            ee = rxe && exp_err && t == eop_at + lat;
            if (lg_chk[t+1] != ec) begin
                if (nchk == 0) begin ca = 32'(t+1); ce = 32'(ec); end
                nchk++;
            end
            if (lg_err[t+1] != ee) nerr++;
        end
        check(npass == 0, req_pass, "rx one-cycle pass", 32'(npass), 0);
        check(nchk == 0, req_flag, "rx_checking window (cycle, exp)", ca, ce);
        check(nerr == 0, req_flag, "rx_crc_err pulse mismatches", 32'(nerr), 0);
    endtask

    task automatic fill_seq(input int n, input logic [7:0] seed);
        pl_n = n;
        for (int i = 0; i < n; i++) pl[i] = seed + 8'(i * 37);
    endtask

    task automatic t_reset;
        check(tx_k_out == 1'b0 && tx_data_out == 8'h00, "R12", "tx out after reset",
              {23'd0, tx_k_out, tx_data_out}, 0);
        check(rx_k_out == 1'b0 && rx_data_out == 8'h00, "R12", "rx out after reset",
              {23'd0, rx_k_out, rx_data_out}, 0);
        check(!rx_checking && !rx_crc_err, "R12", "rx flags after reset",
              {30'd0, rx_checking, rx_crc_err}, 0);
    endtask

    task automatic t_clean;
        sop_code = 8'hFB; eop_code = 8'hFD;
        fill_seq(8, 8'h3A);
        build_frame(1'b0);
        run(1, 1, 0, -1, 0);
        check_tx(1, 1, 0, "R1 R2");
        check_rx(1, 0, LAT, 1, "R6", "R7 R8");
    endtask

    task automatic t_known;
        sop_code = 8'hFB; eop_code = 8'hFD;
        pl_n = 9;
        for (int i = 0; i < 9; i++) pl[i] = 8'h31 + 8'(i);
        build_frame(1'b0);
        run(1, 1, 0, -1, 0);
        check({lg_td[eop_at-4+LAT], lg_td[eop_at-3+LAT], lg_td[eop_at-2+LAT],
               lg_td[eop_at-1+LAT]} == 32'hFC891918, "R2", "check value of 123456789",
              {lg_td[eop_at-4+LAT], lg_td[eop_at-3+LAT], lg_td[eop_at-2+LAT],
               lg_td[eop_at-1+LAT]}, 32'hFC891918);
        check_rx(1, 0, LAT, 1, "R6", "R8");
    endtask

    task automatic t_empty_codes;
        sop_code = 8'h5C; eop_code = 8'h7C;
        pl_n = 0;
        build_frame(1'b0);
        run(1, 1, 0, -1, 0);
        check_tx(1, 1, 0, "R2 R3");
        check_rx(1, 0, LAT, 1, "R6", "R3 R7");
        fill_seq(1, 8'hA5);
        build_frame(1'b0);
        run(1, 1, 0, -1, 0);
        check_tx(1, 1, 0, "R3");
        check_rx(1, 0, LAT, 1, "R6", "R3 R8");
    endtask

    task automatic t_flip;
        sop_code = 8'hFB; eop_code = 8'hFD;
        fill_seq(6, 8'h07);
        build_frame(1'b0);
        run(1, 1, 0, sop_first + 1 + 3 + LAT, 8'h10);
        check_rx(1, 1, LAT, 1, "R6", "R8");
    endtask

    task automatic t_force;
        sop_code = 8'hFB; eop_code = 8'hFD;
        fill_seq(5, 8'hC3);
        build_frame(1'b0);
        run(1, 1, 1, -1, 0);
        check_tx(1, 1, 1, "R4");
        check_rx(1, 1, LAT, 1, "R6", "R4 R8");
    endtask

    task automatic t_restart;
        sop_code = 8'hFB; eop_code = 8'hFD;
        fill_seq(4, 8'h90);
        build_frame(1'b1);
        run(1, 1, 0, -1, 0);
        check_tx(1, 1, 0, "R9");
        check_rx(1, 0, LAT, 1, "R6", "R9");
    endtask

    task automatic t_orphan;
        sop_code = 8'hFB; eop_code = 8'hFD;
        slen = 0;
        add_sym(1'b1, IDLE_D);
        for (int i = 0; i < 6; i++) add_sym(1'b0, 8'h40 + 8'(i));
        eop_at = slen;
        add_sym(1'b1, eop_code);
        for (int i = 0; i < 8; i++) add_sym(1'b1, IDLE_D);
        sop_first = -100;
        pl_n = 0;
        run(1, 1, 0, -1, 0);
        check_tx(1, 0, 0, "R10");
        check_rx(1, 0, LAT, 0, "R6", "R10");
    endtask

    task automatic t_bypass;
        sop_code = 8'hFB; eop_code = 8'hFD;
        fill_seq(7, 8'h21);
        build_frame(1'b0);
        run(0, 0, 0, -1, 0);
        check_tx(0, 0, 0, "R5");
        check_rx(0, 0, 0, 1, "R6", "R11");
        build_frame(1'b0);
        run(1, 0, 0, -1, 0);
        check_tx(1, 1, 0, "R1");
        check_rx(0, 0, LAT, 1, "R6", "R11");
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        sop_code = 8'hFB; eop_code = 8'hFD;
        tx_crc_en = 1'b1; rx_crc_en = 1'b1;
        tx_force_err = 1'b0; tx_k_in = 1'b1; tx_data_in = IDLE_D;
        flip_mask = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_clean();
        t_known();
        t_empty_codes();
        t_flip();
        t_force();
        t_restart();
        t_orphan();
        t_bypass();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule